// File: doc/BRIEF.md
# I2C Event Flag Tracker

This block keeps the four event flags that software polls on an I2C controller: start issued, 10-bit header sent, address sent or matched, and byte transfer finished. The bus engine reports what happened on the wire as single-cycle pulses. These pulses are start generated, address byte acknowledged, NACK received, slave address match (with a match kind), byte received, transmit slot due and stop. Level inputs describe the current mode, such as master or slave, 10-bit addressing, clock stretching and PEC. The block qualifies each pulse against these levels and sets the matching flag.

Software clears the flags through a two-step access protocol on a simple strobe interface. A read of the first status register arms a pending state. The next access decides what is cleared: a data write, a data read, or a read of the second status register. Any other access drops the pending state. Dropping the peripheral enable wipes every flag and all sequencing state in one cycle. The first status register returns the flags at fixed bit positions. Every other bit and every other register reads as zero.

Top module: `i2c_evflag_unit`

## Requirements
- R1: A synchronous active-high reset clears all flags and the pending state. While `periph_en` is 0, every flag is 0 one cycle later and no event sets a flag.
- R2: `ev_start` sets `flag_sb` on the next cycle. `flag_sb` clears only when a status-1 read is followed by a data write (`reg_sel` 0 = status 1, 1 = status 2, 2 = data).
- R3: In master mode with `addr10`=1, the first acknowledged address byte after a start sets `flag_hdr`. `flag_hdr` clears when a status-1 read is followed by a data write.
- R4: In master mode, `flag_addr` sets on the acknowledged address byte when `addr10`=0. When `addr10`=1 it sets only on the second acknowledged address byte.
- R5: In slave mode, `ev_match` sets `flag_addr` for kind 0 (own address) at all times. Kinds 1 to 4 (general call, device default, host, alert) set it only when `match_en` bit kind-1 is 1.
- R6: `flag_addr` clears when a status-1 read is followed by a status-2 read. A data write after a status-1 read leaves it set.
- R7: `flag_btf` sets only while `stretch_en`=1, on one of two conditions. The first is `ev_rx_byte` while `rxne`=1. The second is `ev_tx_slot` while `txe`=1.
- R8: `flag_btf` clears when a status-1 read is followed by a data read or a data write. It also clears on `ev_start` or `ev_stop` while `transmitting`=1.
- R9: In a cycle where `ev_nack` is 1, none of `flag_hdr`, `flag_addr` or `flag_btf` is set.
- R10: `flag_btf` is not set when `transmitting`, `pec_en` and `next_is_pec` are all 1.
- R11: Any access other than the qualifying second access cancels the pending state. A flag event in the same cycle as its clearing access keeps the flag set.
- R12: During a status-1 read, `rd_data` carries the start flag in bit 0, the address flag in bit 1, the byte-finished flag in bit 2 and the header flag in bit 3, with all other bits 0. `rd_data` is 0 for any other access and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_en | input | 1 | Peripheral enable; 0 clears all flags |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| addr10 | input | 1 | Master uses 10-bit addressing |
| stretch_en | input | 1 | Clock stretching allowed |
| transmitting | input | 1 | Controller is the transmitter |
| pec_en | input | 1 | PEC transfer enabled |
| next_is_pec | input | 1 | Next byte to send is the PEC byte |
| rxne | input | 1 | Receive data not yet read |
| txe | input | 1 | Transmit data not yet written |
| ev_start | input | 1 | Start condition generated (pulse) |
| ev_stop | input | 1 | Stop condition (pulse) |
| ev_addr_ack | input | 1 | Master address byte acknowledged (pulse) |
| ev_nack | input | 1 | NACK received (pulse) |
| ev_match | input | 1 | Slave address recognised (pulse) |
| match_kind | input | 3 | Kind of slave match, 0 to 4 |
| match_en | input | 4 | Enables for match kinds 1 to 4 |
| ev_rx_byte | input | 1 | Byte plus ACK received (pulse) |
| ev_tx_slot | input | 1 | Next transmit byte due (pulse) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status 1, 1 status 2, 2 data |
| rd_data | output | DATA_W | Read data |
| flag_sb | output | 1 | Start issued flag |
| flag_hdr | output | 1 | 10-bit header sent flag |
| flag_addr | output | 1 | Address sent or matched flag |
| flag_btf | output | 1 | Byte transfer finished flag |

## Verification
The bench builds the block with `DATA_W` set to 8 instead of the default 16. This keeps the read-data word short while still leaving four bits above the flag field, so the zero-fill of unused status bits is checked. Every slave match kind is reached through the four enable bits. The full two-step sequences are driven against each register, including cancelled sequences and events that collide with their own clearing access.

// File: rtl/i2c_evflag_pkg.sv
package i2c_evflag_pkg;

    localparam int N_FLAGS     = 4;
    localparam int N_OPT_KINDS = 4;
    localparam int KIND_W      = 3;
    localparam int SEL_W       = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_ST1 = 2'd0,
        SEL_ST2 = 2'd1,
        SEL_DAT = 2'd2
    } reg_sel_e;

    // Bit order is the status-1 readback layout.
    typedef struct packed {
        logic hdr;
        logic btf;
        logic addr;
        logic sb;
    } flags_t;

    localparam logic [KIND_W-1:0] KIND_OWN = '0;

    function automatic flags_t flags_none();
        flags_t f;
        f = '0;
        return f;
    endfunction

endpackage

// File: rtl/i2c_evflag_seq.sv
module i2c_evflag_seq
    import i2c_evflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             periph_en,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    output flags_t           sw_clr
);

    logic pending_q;
    logic st1_rd;
    logic any_acc;

    assign st1_rd  = reg_rd && (reg_sel == SEL_ST1);
    assign any_acc = reg_rd || reg_wr;

    always_ff @(posedge clk) begin
        if (rst || !periph_en)
            pending_q <= 1'b0;
        else if (st1_rd)
            pending_q <= 1'b1;
        else if (any_acc)
            pending_q <= 1'b0;
    end

    always_comb begin
        sw_clr = flags_none();
        if (pending_q) begin
            if (reg_wr && reg_sel == SEL_DAT) begin
                sw_clr.sb  = 1'b1;
                sw_clr.hdr = 1'b1;
                sw_clr.btf = 1'b1;
            end
            if (reg_rd && reg_sel == SEL_DAT)
                sw_clr.btf = 1'b1;
            if (reg_rd && reg_sel == SEL_ST2)
                sw_clr.addr = 1'b1;
        end
    end

endmodule

// File: rtl/i2c_evflag_evt.sv
module i2c_evflag_evt
    import i2c_evflag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   periph_en,
    input  logic                   is_master,
    input  logic                   addr10,
    input  logic                   stretch_en,
    input  logic                   transmitting,
    input  logic                   pec_en,
    input  logic                   next_is_pec,
    input  logic                   rxne,
    input  logic                   txe,
    input  logic                   ev_start,
    input  logic                   ev_stop,
    input  logic                   ev_addr_ack,
    input  logic                   ev_nack,
    input  logic                   ev_match,
    input  logic [KIND_W-1:0]      match_kind,
    input  logic [N_OPT_KINDS-1:0] match_en,
    input  logic                   ev_rx_byte,
    input  logic                   ev_tx_slot,
    output flags_t                 hw_set,
    output flags_t                 hw_clr
);

    logic                   hdr_seen_q;
    logic                   ack_ok;
    logic                   hdr_ack;
    logic                   final_ack;
    logic [N_OPT_KINDS-1:0] opt_hit;
    logic                   slave_hit;
    logic                   pec_hold;
    logic                   btf_hit;

    assign ack_ok    = ev_addr_ack && is_master && !ev_nack;
    assign hdr_ack   = ack_ok && addr10 && !hdr_seen_q;
    assign final_ack = ack_ok && (!addr10 || hdr_seen_q);

    genvar k;
    generate
        for (k = 0; k < N_OPT_KINDS; k++) begin : g_kind
            assign opt_hit[k] = (match_kind == KIND_W'(k + 1)) && match_en[k];
        end
    endgenerate

    assign slave_hit = ev_match && !is_master && !ev_nack &&
                       ((match_kind == KIND_OWN) || (|opt_hit));

    assign pec_hold = transmitting && pec_en && next_is_pec;
    assign btf_hit  = stretch_en && !ev_nack &&
                      ((ev_rx_byte && rxne) || (ev_tx_slot && txe && !pec_hold));

    always_ff @(posedge clk) begin
        if (rst || !periph_en)
            hdr_seen_q <= 1'b0;
        else if (ev_start)
            hdr_seen_q <= 1'b0;
        else if (hdr_ack)
            hdr_seen_q <= 1'b1;
        else if (final_ack)
            hdr_seen_q <= 1'b0;
    end

    always_comb begin
        hw_set      = flags_none();
        hw_set.sb   = ev_start;
        hw_set.hdr  = hdr_ack;
        hw_set.addr = final_ack || slave_hit;
        hw_set.btf  = btf_hit;
        hw_clr      = flags_none();
        hw_clr.btf  = (ev_start || ev_stop) && transmitting;
    end

endmodule

// File: rtl/i2c_evflag_bank.sv
module i2c_evflag_bank #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          periph_en,
    input  logic [NF-1:0] set_v,
    input  logic [NF-1:0] clr_v,
    output logic [NF-1:0] flag_q
);

    genvar i;
    generate
        for (i = 0; i < NF; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst || !periph_en)
                    flag_q[i] <= 1'b0;
                else if (set_v[i])
                    flag_q[i] <= 1'b1;
                else if (clr_v[i])
                    flag_q[i] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/i2c_evflag_unit.sv
module i2c_evflag_unit
    import i2c_evflag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   periph_en,
    input  logic                   is_master,
    input  logic                   addr10,
    input  logic                   stretch_en,
    input  logic                   transmitting,
    input  logic                   pec_en,
    input  logic                   next_is_pec,
    input  logic                   rxne,
    input  logic                   txe,
    input  logic                   ev_start,
    input  logic                   ev_stop,
    input  logic                   ev_addr_ack,
    input  logic                   ev_nack,
    input  logic                   ev_match,
    input  logic [2:0]             match_kind,
    input  logic [3:0]             match_en,
    input  logic                   ev_rx_byte,
    input  logic                   ev_tx_slot,
    input  logic                   reg_rd,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_sel,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   flag_sb,
    output logic                   flag_hdr,
    output logic                   flag_addr,
    output logic                   flag_btf
);

    localparam int PAD_W = DATA_W - N_FLAGS;

    flags_t hw_set;
    flags_t hw_clr;
    flags_t sw_clr;
    flags_t flags;
    logic [N_FLAGS-1:0] flag_bits;

    i2c_evflag_evt u_evt (
        .clk          (clk),
        .rst          (rst),
        .periph_en    (periph_en),
        .is_master    (is_master),
        .addr10       (addr10),
        .stretch_en   (stretch_en),
        .transmitting (transmitting),
        .pec_en       (pec_en),
        .next_is_pec  (next_is_pec),
        .rxne         (rxne),
        .txe          (txe),
        .ev_start     (ev_start),
        .ev_stop      (ev_stop),
        .ev_addr_ack  (ev_addr_ack),
        .ev_nack      (ev_nack),
        .ev_match     (ev_match),
        .match_kind   (match_kind),
        .match_en     (match_en),
        .ev_rx_byte   (ev_rx_byte),
        .ev_tx_slot   (ev_tx_slot),
        .hw_set       (hw_set),
        .hw_clr       (hw_clr)
    );

    i2c_evflag_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .periph_en (periph_en),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .sw_clr    (sw_clr)
    );

    i2c_evflag_bank #(.NF(N_FLAGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .periph_en (periph_en),
        .set_v     (hw_set),
        .clr_v     (hw_clr | sw_clr),
        .flag_q    (flag_bits)
    );

    assign flags     = flags_t'(flag_bits);
    assign flag_sb   = flags.sb;
    assign flag_hdr  = flags.hdr;
    assign flag_addr = flags.addr;
    assign flag_btf  = flags.btf;

    assign rd_data = (reg_rd && reg_sel == SEL_ST1) ? {{PAD_W{1'b0}}, flags} : '0;

endmodule

// File: rtl/i2c_evflag_chk.sv
module i2c_evflag_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              periph_en,
    input logic              transmitting,
    input logic              pec_en,
    input logic              next_is_pec,
    input logic              stretch_en,
    input logic              ev_start,
    input logic              ev_nack,
    input logic              ev_rx_byte,
    input logic              reg_rd,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              flag_sb,
    input logic              flag_hdr,
    input logic              flag_addr,
    input logic              flag_btf
);

    assert_pe_wipe_R1: assert property (@(posedge clk) disable iff (rst)
        !periph_en |=> !(flag_sb || flag_hdr || flag_addr || flag_btf));

    assert_start_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (periph_en && ev_start) |=> flag_sb);

    assert_addr_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_addr) |-> $past((reg_rd && reg_sel == 2'd1) || !periph_en));

    assert_btf_stretch_R7: assert property (@(posedge clk) disable iff (rst)
        (!stretch_en && !flag_btf) |=> !flag_btf);

    assert_nack_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_nack && !flag_addr) |=> !flag_addr);

    assert_nack_btf_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_nack && !flag_btf) |=> !flag_btf);

    assert_nack_hdr_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_nack && !flag_hdr) |=> !flag_hdr);

    assert_pec_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (transmitting && pec_en && next_is_pec && !ev_rx_byte && !flag_btf)
        |=> !flag_btf);

    assert_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_sel == 2'd0) |-> (rd_data == '0));

    assert_read_pad_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_data >> 4) == '0);

endmodule

bind i2c_evflag_unit i2c_evflag_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .periph_en    (periph_en),
    .transmitting (transmitting),
    .pec_en       (pec_en),
    .next_is_pec  (next_is_pec),
    .stretch_en   (stretch_en),
    .ev_start     (ev_start),
    .ev_nack      (ev_nack),
    .ev_rx_byte   (ev_rx_byte),
    .reg_rd       (reg_rd),
    .reg_sel      (reg_sel),
    .rd_data      (rd_data),
    .flag_sb      (flag_sb),
    .flag_hdr     (flag_hdr),
    .flag_addr    (flag_addr),
    .flag_btf     (flag_btf)
);

// File: tb/tb_i2c_evflag_unit.sv
module tb_i2c_evflag_unit;

    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic periph_en = 1'b0, is_master = 1'b0, addr10 = 1'b0, stretch_en = 1'b0;
    logic transmitting = 1'b0, pec_en = 1'b0, next_is_pec = 1'b0, rxne = 1'b0, txe = 1'b0;
    logic ev_start = 1'b0, ev_stop = 1'b0, ev_addr_ack = 1'b0, ev_nack = 1'b0, ev_match = 1'b0;
    logic [2:0] match_kind = '0;
    logic [3:0] match_en = '0;
    logic ev_rx_byte = 1'b0, ev_tx_slot = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [DW-1:0] rd_data;
    logic flag_sb, flag_hdr, flag_addr, flag_btf;

    int n_checks = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    i2c_evflag_unit #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .periph_en(periph_en), .is_master(is_master),
        .addr10(addr10), .stretch_en(stretch_en), .transmitting(transmitting),
        .pec_en(pec_en), .next_is_pec(next_is_pec), .rxne(rxne), .txe(txe),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_addr_ack(ev_addr_ack),
        .ev_nack(ev_nack), .ev_match(ev_match), .match_kind(match_kind),
        .match_en(match_en), .ev_rx_byte(ev_rx_byte), .ev_tx_slot(ev_tx_slot),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .rd_data(rd_data),
        .flag_sb(flag_sb), .flag_hdr(flag_hdr), .flag_addr(flag_addr), .flag_btf(flag_btf)
    );

    function automatic logic [3:0] cur_flags();
        return {flag_hdr, flag_btf, flag_addr, flag_sb};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // One-cycle register access; returns rd_data seen during the access.
    task automatic access(input logic rd, input logic [1:0] sel, output logic [DW-1:0] val);
        reg_rd = rd; reg_wr = !rd; reg_sel = sel;
        #1 val = rd_data;
        step();
        reg_rd = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0;
    endtask

    task automatic wipe();
        periph_en = 1'b0; step(); periph_en = 1'b1;
        is_master = 1'b0; addr10 = 1'b0; stretch_en = 1'b0; transmitting = 1'b0;
        pec_en = 1'b0; next_is_pec = 1'b0; rxne = 1'b0; txe = 1'b0; match_en = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check("R1 reset flags", 32'(cur_flags()), 32'h0);
        periph_en = 1'b1;
        access(1'b1, 2'd0, v);
        check("R1 reset readback", 32'(v), 32'h0);
    endtask

    task automatic t_start();
        logic [DW-1:0] v;
        wipe();
        ev_start = 1'b1; step(); ev_start = 1'b0;
        check("R2 start sets", 32'(flag_sb), 32'h1);
        access(1'b0, 2'd2, v);
        check("R2 data write alone keeps", 32'(flag_sb), 32'h1);
        access(1'b1, 2'd0, v);
        check("R12 sb at bit0", 32'(v), 32'h01);
        access(1'b0, 2'd2, v);
        check("R2 st1 read then data write clears", 32'(flag_sb), 32'h0);
    endtask

    task automatic t_master7();
        logic [DW-1:0] v;
        wipe();
        is_master = 1'b1;
        ev_addr_ack = 1'b1; step(); ev_addr_ack = 1'b0;
        check("R4 7-bit ack sets addr", 32'(cur_flags()), 32'h2);
        access(1'b1, 2'd0, v);
        check("R12 addr at bit1", 32'(v), 32'h02);
        access(1'b0, 2'd2, v);
        check("R6 data write keeps addr", 32'(flag_addr), 32'h1);
        access(1'b1, 2'd0, v);
        access(1'b1, 2'd1, v);
        check("R6 st1 then st2 clears", 32'(flag_addr), 32'h0);
        check("R12 st2 reads zero", 32'(v), 32'h0);
    endtask

    task automatic t_master10();
        logic [DW-1:0] v;
        wipe();
        is_master = 1'b1; addr10 = 1'b1;
        ev_start = 1'b1; step(); ev_start = 1'b0;
        ev_addr_ack = 1'b1; step(); ev_addr_ack = 1'b0;
        check("R3 header ack sets hdr, not addr", 32'(cur_flags()), 32'h9);
        access(1'b1, 2'd0, v);
        check("R12 hdr at bit3", 32'(v), 32'h09);
        access(1'b0, 2'd2, v);
        check("R3 st1 then data write clears hdr and sb", 32'(cur_flags()), 32'h0);
        ev_addr_ack = 1'b1; step(); ev_addr_ack = 1'b0;
        check("R4 second ack sets addr", 32'(cur_flags()), 32'h2);
    endtask

    task automatic t_slave();
        logic [DW-1:0] v;
        wipe();
        match_kind = 3'd0; ev_match = 1'b1; step(); ev_match = 1'b0;
        check("R5 own match sets", 32'(flag_addr), 32'h1);
        for (int k = 1; k <= 4; k++) begin
            wipe();
            match_kind = 3'(k); ev_match = 1'b1; step(); ev_match = 1'b0;
            check("R5 disabled kind ignored", 32'(flag_addr), 32'h0);
            match_en = 4'(1 << (k - 1));
            ev_match = 1'b1; step(); ev_match = 1'b0;
            check("R5 enabled kind sets", 32'(flag_addr), 32'h1);
        end
        wipe();
        is_master = 1'b1; match_kind = 3'd0; ev_match = 1'b1; step(); ev_match = 1'b0;
        check("R5 match ignored in master", 32'(flag_addr), 32'h0);
        access(1'b1, 2'd1, v);
    endtask

    task automatic t_btf();
        logic [DW-1:0] v;
        wipe();
        rxne = 1'b1;
        ev_rx_byte = 1'b1; step(); ev_rx_byte = 1'b0;
        check("R7 no stretch no set", 32'(flag_btf), 32'h0);
        stretch_en = 1'b1; rxne = 1'b0;
        ev_rx_byte = 1'b1; step(); ev_rx_byte = 1'b0;
        check("R7 rxne low no set", 32'(flag_btf), 32'h0);
        rxne = 1'b1;
        ev_rx_byte = 1'b1; step(); ev_rx_byte = 1'b0;
        check("R7 rx sets", 32'(flag_btf), 32'h1);
        access(1'b1, 2'd0, v);
        check("R12 btf at bit2", 32'(v), 32'h04);
        access(1'b1, 2'd2, v);
        check("R8 st1 then data read clears", 32'(flag_btf), 32'h0);
        transmitting = 1'b1; txe = 1'b1;
        ev_tx_slot = 1'b1; step(); ev_tx_slot = 1'b0;
        check("R7 tx sets", 32'(flag_btf), 32'h1);
        ev_stop = 1'b1; step(); ev_stop = 1'b0;
        check("R8 stop while tx clears", 32'(flag_btf), 32'h0);
        ev_tx_slot = 1'b1; step(); ev_tx_slot = 1'b0;
        access(1'b1, 2'd0, v);
        access(1'b0, 2'd2, v);
        check("R8 st1 then data write clears", 32'(flag_btf), 32'h0);
        transmitting = 1'b0;
        ev_rx_byte = 1'b1; step(); ev_rx_byte = 1'b0;
        ev_stop = 1'b1; step(); ev_stop = 1'b0;
        check("R8 stop while rx keeps", 32'(flag_btf), 32'h1);
    endtask

    task automatic t_nack();
        wipe();
        is_master = 1'b1; stretch_en = 1'b1; rxne = 1'b1;
        ev_addr_ack = 1'b1; ev_nack = 1'b1; ev_rx_byte = 1'b1; step();
        ev_addr_ack = 1'b0; ev_nack = 1'b0; ev_rx_byte = 1'b0;
        check("R9 nack suppresses", 32'(cur_flags()), 32'h0);
        addr10 = 1'b1;
        ev_addr_ack = 1'b1; ev_nack = 1'b1; step();
        ev_addr_ack = 1'b0; ev_nack = 1'b0;
        check("R9 nack suppresses hdr", 32'(flag_hdr), 32'h0);
    endtask

    task automatic t_pec();
        wipe();
        stretch_en = 1'b1; transmitting = 1'b1; txe = 1'b1; pec_en = 1'b1; next_is_pec = 1'b1;
        ev_tx_slot = 1'b1; step(); ev_tx_slot = 1'b0;
        check("R10 pec byte no set", 32'(flag_btf), 32'h0);
        next_is_pec = 1'b0;
        ev_tx_slot = 1'b1; step(); ev_tx_slot = 1'b0;
        check("R10 normal byte sets", 32'(flag_btf), 32'h1);
    endtask

    task automatic t_cancel();
        logic [DW-1:0] v;
        wipe();
        ev_start = 1'b1; step(); ev_start = 1'b0;
        access(1'b1, 2'd0, v);
        access(1'b1, 2'd1, v);
        access(1'b0, 2'd2, v);
        check("R11 st2 read cancels pending", 32'(flag_sb), 32'h1);
        access(1'b1, 2'd0, v);
        reg_wr = 1'b1; reg_sel = 2'd2; ev_start = 1'b1; step();
        reg_wr = 1'b0; ev_start = 1'b0;
        check("R11 event beats clear", 32'(flag_sb), 32'h1);
        access(1'b0, 2'd2, v);
        check("R11 pending consumed", 32'(flag_sb), 32'h1);
    endtask

    task automatic t_pe();
        logic [DW-1:0] v;
        wipe();
        is_master = 1'b1; stretch_en = 1'b1; rxne = 1'b1;
        ev_start = 1'b1; step(); ev_start = 1'b0;
        ev_addr_ack = 1'b1; ev_rx_byte = 1'b1; step();
        ev_addr_ack = 1'b0; ev_rx_byte = 1'b0;
        check("R1 flags before disable", 32'(cur_flags()), 32'h7);
        access(1'b1, 2'd0, v);
        periph_en = 1'b0; ev_start = 1'b1; step(); ev_start = 1'b0;
        check("R1 disable wipes and blocks", 32'(cur_flags()), 32'h0);
        periph_en = 1'b1;
        ev_start = 1'b1; step(); ev_start = 1'b0;
        access(1'b0, 2'd2, v);
        check("R1 pending wiped", 32'(flag_sb), 32'h1);
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        n_checks++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_start();
        t_master7();
        t_master10();
        t_slave();
        t_btf();
        t_nack();
        t_pec();
        t_cancel();
        t_pe();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule